// File: doc/BRIEF.md
# Status Byte and Write Guard for a Serial Memory

This block keeps the status byte of a serial-attached nonvolatile memory and decides which writes may go ahead. The status byte holds a busy flag, a write-enable latch, a two-bit array protection level and a bit that arms the external guard pin. The command decoder hands the block strobes: write enable, write disable, a staged status byte, chip-select state and the end of each internal program cycle. The block answers with the byte that a status read returns and with two permits. One permit pulses when a staged status write may start its timed cycle. The other is a level that says whether an array write to the presented address may be committed.

A status write is staged while the device is selected and is judged in the cycle in which chip select is released. If it is granted, the new protection level and guard-enable bit are taken into the register on the next end-of-cycle pulse. Every end-of-cycle pulse clears the write-enable latch, so each program operation needs a fresh enable. The nonvolatile bits come out of reset at parameter values.

Top module: `spiStatusGuard`

## Requirements
- R1: After reset the status byte reads {guard-enable reset value, 3'b000, protection-level reset value, 1'b0, 1'b0}, which is 8'h00 with the default parameters.
- R2: While busy is low, bit 0 reads 0, bit 1 is the write-enable latch, bits 3:2 are the protection level, bits 6:4 read 0 and bit 7 is the guard-enable bit.
- R3: While busy is high the status byte reads 8'hFF.
- R4: The write-enable strobe sets the latch only while the guard pin is high and busy is low. The write-disable strobe clears it whatever the pin state, and it wins over a simultaneous enable.
- R5: An end-of-cycle pulse clears the write-enable latch.
- R6: A status byte loaded while selected and not busy becomes pending. In the cycle where chip select falls from active to inactive, the status permit is high exactly when a write is pending, the latch is set and the hardware lock (guard-enable 1 with guard pin low) is off. A pending write is dropped at every deselect.
- R7: After a granted status write, the next end-of-cycle pulse loads the protection level from data bits 3:2 and guard-enable from data bit 7. All other data bits are ignored.
- R8: A falling guard pin while selected, with guard-enable 1, cancels the pending status write even if the pin rises again before deselect.
- R9: The array permit is high only with the latch set, busy low and the address outside the protected range. The range depends on the level: 00 none, 01 the top quarter (top two address bits 11), 10 the top half (top address bit 1), 11 the whole array.
- R10: The write-enable and status-load strobes are ignored while busy is high.
- R11: With guard-enable 0 the guard pin does not block a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csActive | input | 1 | Device selected (1 while chip select is asserted) |
| guardPin | input | 1 | Guard pin level, low requests protection |
| busy | input | 1 | Internal program cycle in progress |
| wrEnStb | input | 1 | Write-enable command strobe |
| wrDisStb | input | 1 | Write-disable command strobe |
| statLoad | input | 1 | Status-write data byte received |
| statData | input | 8 | Status-write data byte |
| cycleDone | input | 1 | End-of-program-cycle pulse |
| arrAddr | input | ADDR_W | Target address of an array write |
| statusByte | output | 8 | Value returned by a status read |
| statPermit | output | 1 | Pulse: staged status write may start its cycle |
| arrPermit | output | 1 | Array write to arrAddr may be committed |

## Verification
The bench goes after the protection boundaries: the first address of the top quarter and of the top half, and the address just below each. A wrong compare there would refuse writes to free memory or let a write land in locked memory. It checks that a pin glitch while selected cancels a pending status write even after the pin recovers. A design that samples the pin only at deselect would grant that write. It checks that a locked guard-enable bit cannot be cleared, that a disable beats a simultaneous enable, and that enables are dropped while busy. Getting these wrong would leave the device writable when it should not be. A long random run compares every output on every cycle with a bench model.

// File: rtl/spiStatusGuardPkg.sv
package spiStatusGuardPkg;

  typedef struct packed {
    logic setWe;
    logic clrWe;
    logic load;
    logic commit;
  } guardStrobes_t;

  // Protection level decode: true when the top two address bits fall in the locked range
  function automatic logic levelLocks(input logic [1:0] level, input logic [1:0] topBits);
    case (level)
      2'b00:   levelLocks = 1'b0;
      2'b01:   levelLocks = (topBits == 2'b11);
      2'b10:   levelLocks = topBits[1];
      default: levelLocks = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spiStatusGuardCtrl.sv
module spiStatusGuardCtrl
  import spiStatusGuardPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          csActive,
  input  logic          guardPin,
  input  logic          busy,
  input  logic          wrEnStb,
  input  logic          wrDisStb,
  input  logic          statLoad,
  input  logic          cycleDone,
  input  logic          weBit,
  input  logic          penBit,
  output guardStrobes_t strb,
  output logic          statPermit
);

  logic csPrev;
  logic guardPrev;
  logic pending;
  logic armed;

  logic deselect;
  logic hwLock;
  logic guardFall;
  logic abortNow;
  logic loadOk;

  assign deselect  = csPrev & ~csActive;
  assign hwLock    = penBit & ~guardPin;
  assign guardFall = guardPrev & ~guardPin;
  assign abortNow  = penBit & guardFall & csActive & pending;
  assign loadOk    = statLoad & csActive & ~busy;

  assign statPermit = deselect & pending & weBit & ~hwLock;

  always_comb begin
    strb.setWe  = wrEnStb & guardPin & ~busy;
    strb.clrWe  = wrDisStb | cycleDone;
    strb.load   = loadOk;
    strb.commit = cycleDone & armed;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev    <= 1'b0;
      guardPrev <= 1'b1;
      pending   <= 1'b0;
      armed     <= 1'b0;
    end else begin
      csPrev    <= csActive;
      guardPrev <= guardPin;
      if (deselect)      pending <= 1'b0;
      else if (loadOk)   pending <= 1'b1;
      else if (abortNow) pending <= 1'b0;
      if (statPermit)     armed <= 1'b1;
      else if (cycleDone) armed <= 1'b0;
    end
  end

  AST_PERMIT_AT_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    statPermit |-> ($past(csActive) && !csActive)); // R6

  AST_GLITCH_CANCELS: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(guardPin) && csActive && penBit && !statLoad) |=> !pending); // R8

endmodule

// File: rtl/spiStatusGuardDatapath.sv
module spiStatusGuardDatapath
  import spiStatusGuardPkg::*;
#(
  parameter int         ADDR_W    = 15,
  parameter logic [1:0] LVL_RESET = 2'b00,
  parameter logic       PEN_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobes_t     strb,
  input  logic [7:0]        statData,
  input  logic              busy,
  input  logic [ADDR_W-1:0] arrAddr,
  output logic              weBit,
  output logic              penBit,
  output logic [7:0]        statusByte,
  output logic              arrPermit
);

  localparam int TOP = ADDR_W - 1;

  logic [1:0] level;
  logic [1:0] stagedLevel;
  logic       stagedPen;
  logic [4:0] dataUnused;
  logic       addrLocked;

  assign dataUnused = {statData[6:4], statData[1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weBit       <= 1'b0;
      level       <= LVL_RESET;
      penBit      <= PEN_RESET;
      stagedLevel <= 2'b00;
      stagedPen   <= 1'b0;
    end else begin
      if (strb.clrWe)      weBit <= 1'b0;
      else if (strb.setWe) weBit <= 1'b1;
      if (strb.load) begin
        stagedLevel <= statData[3:2];
        stagedPen   <= statData[7];
      end
      if (strb.commit) begin
        level  <= stagedLevel;
        penBit <= stagedPen;
      end
    end
  end

  assign addrLocked = levelLocks(level, arrAddr[TOP -: 2]);
  assign arrPermit  = weBit & ~busy & ~addrLocked;
  assign statusByte = busy ? 8'hFF : {penBit, 3'b000, level, weBit, 1'b0};

  AST_LEVEL_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(level)); // R7

  AST_ALL_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (level == 2'b11) |-> !arrPermit); // R9

endmodule

// File: rtl/spiStatusGuard.sv
module spiStatusGuard
  import spiStatusGuardPkg::*;
#(
  parameter int         ADDR_W    = 15,
  parameter logic [1:0] LVL_RESET = 2'b00,
  parameter logic       PEN_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              guardPin,
  input  logic              busy,
  input  logic              wrEnStb,
  input  logic              wrDisStb,
  input  logic              statLoad,
  input  logic [7:0]        statData,
  input  logic              cycleDone,
  input  logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        statusByte,
  output logic              statPermit,
  output logic              arrPermit
);

  guardStrobes_t strb;
  logic          weBit;
  logic          penBit;

  spiStatusGuardCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csActive   (csActive),
    .guardPin   (guardPin),
    .busy       (busy),
    .wrEnStb    (wrEnStb),
    .wrDisStb   (wrDisStb),
    .statLoad   (statLoad),
    .cycleDone  (cycleDone),
    .weBit      (weBit),
    .penBit     (penBit),
    .strb       (strb),
    .statPermit (statPermit)
  );

  spiStatusGuardDatapath #(
    .ADDR_W    (ADDR_W),
    .LVL_RESET (LVL_RESET),
    .PEN_RESET (PEN_RESET)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .statData   (statData),
    .busy       (busy),
    .arrAddr    (arrAddr),
    .weBit      (weBit),
    .penBit     (penBit),
    .statusByte (statusByte),
    .arrPermit  (arrPermit)
  );

  AST_ENABLE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weBit) |-> $past(guardPin)); // R4

  AST_DONE_CLEARS_WE: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !weBit); // R5

  AST_ARRAY_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    arrPermit |-> (!busy && statusByte[1])); // R9

  AST_PEN_HELD_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (penBit && !guardPin && !cycleDone) |=> penBit); // R6

endmodule

// File: tb/spiStatusGuard_bench.sv
module spiStatusGuard_bench;

  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rstN;
  logic          csActive, guardPin, busy, wrEnStb, wrDisStb, statLoad, cycleDone;
  logic [7:0]    statData;
  logic [AW-1:0] arrAddr;
  logic [7:0]    statusByte;
  logic          statPermit, arrPermit;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // bench model state
  logic       mWe, mPen, mStagedPen, mPend, mArmed, mCsPrev, mPinPrev;
  logic [1:0] mLvl, mStagedLvl;
  logic       sawPermit, sawArr;

  always #2.5 clk = ~clk;

  spiStatusGuard #(.ADDR_W(AW)) u_spiStatusGuard (
    .clk(clk), .rstN(rstN), .csActive(csActive), .guardPin(guardPin), .busy(busy),
    .wrEnStb(wrEnStb), .wrDisStb(wrDisStb), .statLoad(statLoad), .statData(statData),
    .cycleDone(cycleDone), .arrAddr(arrAddr), .statusByte(statusByte),
    .statPermit(statPermit), .arrPermit(arrPermit)
  );

  function automatic logic expLocked(input logic [1:0] lvl, input logic [AW-1:0] a);
    case (lvl)
      2'b00:   return 1'b0;
      2'b01:   return a[AW-1] & a[AW-2];
      2'b10:   return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] expStatus(input logic b);
    return b ? 8'hFF : {mPen, 3'b000, mLvl, mWe, 1'b0};
  endfunction

  function automatic logic expPermit(input logic cs, input logic pin);
    return mCsPrev & ~cs & mPend & mWe & ~(mPen & ~pin);
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    testsRun++;
    if (got != exp) begin
      testsFailed++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input logic cs, input logic pin, input logic b, input logic en,
                      input logic dis, input logic ld, input logic [7:0] d,
                      input logic done, input logic [AW-1:0] a);
    logic perm, setOk, ldOk, abortNow;
    @(negedge clk);
    csActive = cs; guardPin = pin; busy = b; wrEnStb = en; wrDisStb = dis;
    statLoad = ld; statData = d; cycleDone = done; arrAddr = a;
    #1;
    perm = expPermit(cs, pin);
    chk(b ? "R3" : "R2", statusByte, expStatus(b));
    chk("R6", statPermit, perm);
    chk("R9", arrPermit, mWe & ~b & ~expLocked(mLvl, a));
    sawPermit = statPermit;
    sawArr = arrPermit;
    @(posedge clk);
    setOk = en & pin & ~b;
    ldOk = ld & cs & ~b;
    abortNow = mPen & mPinPrev & ~pin & cs & mPend;
    if (done && mArmed) begin mLvl = mStagedLvl; mPen = mStagedPen; end
    if (ldOk) begin mStagedLvl = d[3:2]; mStagedPen = d[7]; end
    if (dis || done) mWe = 1'b0; else if (setOk) mWe = 1'b1;
    if (mCsPrev && !cs) mPend = 1'b0; else if (ldOk) mPend = 1'b1; else if (abortNow) mPend = 1'b0;
    if (perm) mArmed = 1'b1; else if (done) mArmed = 1'b0;
    mCsPrev = cs; mPinPrev = pin;
    #1;
  endtask

  task automatic idle();
    step(0, 1, 0, 0, 0, 0, 8'h00, 0, '0);
  endtask

  task automatic statusWrite(input logic [7:0] d);
    step(0, 1, 0, 1, 0, 0, 8'h00, 0, '0);
    step(1, 1, 0, 0, 0, 1, d, 0, '0);
    step(0, 1, 0, 0, 0, 0, 8'h00, 0, '0);
    chk("R6", sawPermit, 1);
    step(0, 1, 1, 0, 0, 0, 8'h00, 1, '0);
    idle();
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rstN = 0; csActive = 0; guardPin = 1; busy = 0; wrEnStb = 0; wrDisStb = 0;
    statLoad = 0; statData = 0; cycleDone = 0; arrAddr = '0;
    mWe = 0; mPen = 0; mLvl = 2'b00; mStagedLvl = 0; mStagedPen = 0;
    mPend = 0; mArmed = 0; mCsPrev = 0; mPinPrev = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1 chk("R1", statusByte, 8'h00);

    // R4 enable gating and disable priority
    step(0, 0, 0, 1, 0, 0, 8'h00, 0, '0);
    chk("R4", statusByte, 8'h00);
    step(0, 1, 0, 1, 0, 0, 8'h00, 0, '0);
    chk("R4", statusByte, 8'h02);
    step(0, 0, 0, 0, 1, 0, 8'h00, 0, '0);
    chk("R4", statusByte, 8'h00);
    step(0, 1, 0, 1, 1, 0, 8'h00, 0, '0);
    chk("R4", statusByte, 8'h00);

    // R10 enable ignored while busy, R3 all ones
    step(0, 1, 1, 1, 0, 0, 8'h00, 0, '0);
    chk("R3", statusByte, 8'hFF);
    idle();
    chk("R10", statusByte, 8'h00);

    // R7 status write, ignored bits
    statusWrite(8'h8E);
    chk("R7", statusByte, 8'h8C);
    chk("R2", statusByte[6:4], 0);

    // R9 whole array locked
    step(0, 1, 0, 1, 0, 0, 8'h00, 0, '0);
    step(0, 1, 0, 0, 0, 0, 8'h00, 0, 15'h0000);
    chk("R9", sawArr, 0);

    // R6 hardware lock blocks status write
    step(1, 0, 0, 0, 0, 0, 8'h00, 0, '0);
    step(1, 0, 0, 0, 0, 1, 8'h00, 0, '0);
    step(0, 0, 0, 0, 0, 0, 8'h00, 0, '0);
    chk("R6", sawPermit, 0);
    idle();
    chk("R6", statusByte, 8'h8E);

    // R8 pin glitch while selected cancels
    step(1, 1, 0, 0, 0, 1, 8'h04, 0, '0);
    step(1, 0, 0, 0, 0, 0, 8'h00, 0, '0);
    step(1, 1, 0, 0, 0, 0, 8'h00, 0, '0);
    step(0, 1, 0, 0, 0, 0, 8'h00, 0, '0);
    chk("R8", sawPermit, 0);
    step(0, 1, 1, 0, 0, 0, 8'h00, 1, '0);
    idle();
    chk("R8", statusByte, 8'h8C);

    // release to level 01, guard off
    statusWrite(8'h04);
    chk("R7", statusByte, 8'h04);

    // R11 guard pin ignored with guard-enable 0
    step(0, 1, 0, 1, 0, 0, 8'h00, 0, '0);
    step(1, 0, 0, 0, 0, 1, 8'h08, 0, '0);
    step(0, 0, 0, 0, 0, 0, 8'h00, 0, '0);
    chk("R11", sawPermit, 1);
    step(0, 0, 1, 0, 0, 0, 8'h00, 1, '0);
    idle();
    chk("R11", statusByte, 8'h08);

    // R9 half boundary
    step(0, 1, 0, 1, 0, 0, 8'h00, 0, '0);
    step(0, 1, 0, 0, 0, 0, 8'h00, 0, 15'h4000);
    chk("R9", sawArr, 0);
    step(0, 1, 0, 0, 0, 0, 8'h00, 0, 15'h3FFF);
    chk("R9", sawArr, 1);
    step(0, 1, 1, 0, 0, 0, 8'h00, 0, 15'h0000);
    chk("R9", sawArr, 0);

    // R9 quarter boundary
    statusWrite(8'h04);
    step(0, 1, 0, 1, 0, 0, 8'h00, 0, '0);
    step(0, 1, 0, 0, 0, 0, 8'h00, 0, 15'h6000);
    chk("R9", sawArr, 0);
    step(0, 1, 0, 0, 0, 0, 8'h00, 0, 15'h5FFF);
    chk("R9", sawArr, 1);

    // R5 end of cycle clears enable
    step(0, 1, 1, 0, 0, 0, 8'h00, 1, '0);
    idle();
    chk("R5", statusByte[1], 0);

    // random phase, every cycle compared with the model
    for (int i = 0; i < 4000; i++) begin
      logic cs, pin;
      cs  = ($urandom % 4 == 0) ? ~mCsPrev : mCsPrev;
      pin = ($urandom % 5 != 0);
      step(cs, pin, ($urandom % 5 == 0), ($urandom % 3 == 0), ($urandom % 12 == 0),
           ($urandom % 3 == 0), 8'($urandom), ($urandom % 7 == 0), AW'($urandom));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule